// File: doc/BRIEF.md
# Sequential Saturating 32-by-15 Unsigned Divider

This block divides a 32-bit unsigned numerator by a 15-bit unsigned denominator over several clock cycles. It returns a 15-bit quotient and a 17-bit remainder using restoring trial subtraction, and it decides one quotient bit per cycle. The running remainder and the quotient bits gathered so far live together in one 32-bit working register. Each cycle applies one fused step to that register: compare, conditional subtract, shift left, and insert the new bit. After the last step, the upper 17 bits hold the remainder and the lower 15 bits hold the quotient.

A caller holds the numerator and denominator on the inputs and raises `start` for one cycle while `busy` is low. The block first checks whether the quotient fits in 15 bits. If it does not fit, or if the denominator is zero, the block skips the iteration and reports a saturated result.

The controller is a three-state machine:
- **IDLE**: waiting for `start`.
- **STEP**: one fused iteration per cycle, for 15 cycles.
- **FINISH**: `done` is high for one cycle.

Its transitions are:
- IDLE→STEP on an accepted start without overflow.
- IDLE→FINISH on an accepted start with overflow.
- STEP→STEP while steps remain.
- STEP→FINISH after the fifteenth step.
- FINISH→IDLE unconditionally.

Top module: `seqdiv_sat`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done` and `ovf` are 0, and `q` and `r` are 0.
- R2: When `d` is non-zero and `n[31:15] < d`, the result has `q` = floor(n/d), `r` = n mod d and `ovf` = 0. This holds up to the boundary n = d·2^15 − 1.
- R3: When `n[31:15] >= d` (the quotient does not fit in 15 bits), the result has `ovf` = 1, `q` = 15'h7fff and `r` = 0.
- R4: A zero denominator is always reported as overflow, with `q` = 15'h7fff and `ovf` = 1.
- R5: A start accepted without overflow at clock edge E0 makes `busy` high from E0 on. `done` is then high for the single cycle that follows edge E15.
- R6: A start accepted with overflow at edge E0 makes `done` high for the single cycle that follows E0.
- R7: `done` is high for exactly one cycle, and `busy` falls on the edge that ends that cycle.
- R8: `start` is ignored while `busy` is high. Operand changes and a start pulse during a run do not alter that run's result or its timing.
- R9: `q`, `r` and `ovf` change only on the edge where `done` rises, and they hold their values until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only while idle |
| n | input | 32 | Unsigned numerator, sampled when start is accepted |
| d | input | 15 | Unsigned denominator, sampled when start is accepted |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| q | output | 15 | Quotient, saturated to 15'h7fff on overflow |
| r | output | 17 | Remainder, zero on overflow |
| ovf | output | 1 | The last result overflowed |

## Verification
The embedded assertions check the following on every cycle:
- The remainder of a non-overflow result is below the latched denominator.
- A saturated result always carries 15'h7fff and a zero remainder.
- No fused step ever drops a set bit off the top of the working register.
- `done` never lasts two cycles, and `busy` only rises after a start.
- The outputs move only when `done` rises.

The exact quotient and remainder values, the overflow boundary, the latency of both paths, and the immunity of a run to mid-run operand changes and start pulses can only be shown by the bench's scenarios.

// File: rtl/seqdiv_pkg.sv
`timescale 1ns/1ps
package seqdiv_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_STEP,
        S_FINISH
    } div_state_t;
endpackage

// File: rtl/seqdiv_ovf_check.sv
`timescale 1ns/1ps
// Decides whether the quotient can exceed the quotient width.
// A zero denominator always compares as overflow.
module seqdiv_ovf_check #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 15,
    localparam int HI_W = NUM_W - DEN_W
) (
    input  logic [HI_W-1:0]  num_hi,
    input  logic [DEN_W-1:0] den,
    output logic             ovf
);
    always_comb begin
        ovf = (num_hi >= {{(HI_W-DEN_W){1'b0}}, den});
    end
endmodule

// File: rtl/seqdiv_step.sv
`timescale 1ns/1ps
// One fused iteration: trial-subtract den from the upper window, keep the
// difference when it is non-negative, then shift left and insert the bit.
module seqdiv_step #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 15,
    localparam int HI_W  = NUM_W - DEN_W,
    localparam int WIN_W = HI_W + 1
) (
    input  logic [NUM_W-1:0] w_cur,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] w_next,
    output logic             qbit,
    output logic             lost_bit
);
    logic [WIN_W-1:0] win;
    logic [WIN_W:0]   diff;
    logic [WIN_W-1:0] win_new;

    always_comb begin
        win      = w_cur[NUM_W-1:DEN_W-1];
        diff     = {1'b0, win} - {{(WIN_W+1-DEN_W){1'b0}}, den};
        qbit     = ~diff[WIN_W];
        win_new  = qbit ? diff[WIN_W-1:0] : win;
        lost_bit = win_new[WIN_W-1];
        w_next   = {win_new[WIN_W-2:0], w_cur[DEN_W-2:0], qbit};
    end
endmodule

// File: rtl/seqdiv_ctrl.sv
`timescale 1ns/1ps
module seqdiv_ctrl
    import seqdiv_pkg::*;
#(
    parameter int Q_W = 15,
    localparam int CNT_W = $clog2(Q_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ovf_now,
    output logic busy,
    output logic done,
    output logic load,
    output logic sat,
    output logic step_en,
    output logic last
);
    div_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= '0;
        else if (step_en) cnt <= cnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = ovf_now ? S_FINISH : S_STEP;
            S_STEP:   if (cnt == CNT_W'(Q_W-1)) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state != S_IDLE);
        done    = (state == S_FINISH);
        load    = (state == S_IDLE) && start && !ovf_now;
        sat     = (state == S_IDLE) && start && ovf_now;
        step_en = (state == S_STEP);
        last    = step_en && (cnt == CNT_W'(Q_W-1));
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R5
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP) |-> (cnt <= CNT_W'(Q_W-1)));
endmodule

// File: rtl/seqdiv_sat.sv
`timescale 1ns/1ps
module seqdiv_sat #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 15,
    localparam int Q_W = DEN_W,
    localparam int R_W = NUM_W - DEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] n,
    input  logic [DEN_W-1:0] d,
    output logic             busy,
    output logic             done,
    output logic [Q_W-1:0]   q,
    output logic [R_W-1:0]   r,
    output logic             ovf
);
    logic [NUM_W-1:0] w_reg, w_next;
    logic [DEN_W-1:0] d_q;
    logic ovf_now, load, sat, step_en, last, qbit, lost_bit;

    seqdiv_ovf_check #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_ovf (
        .num_hi (n[NUM_W-1:Q_W]),
        .den    (d),
        .ovf    (ovf_now)
    );

    seqdiv_step #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_step (
        .w_cur    (w_reg),
        .den      (d_q),
        .w_next   (w_next),
        .qbit     (qbit),
        .lost_bit (lost_bit)
    );

    seqdiv_ctrl #(.Q_W(Q_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ovf_now (ovf_now),
        .busy    (busy),
        .done    (done),
        .load    (load),
        .sat     (sat),
        .step_en (step_en),
        .last    (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_reg <= '0;
            d_q   <= '0;
        end else if (load) begin
            w_reg <= n;
            d_q   <= d;
        end else if (step_en) begin
            w_reg <= w_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            r   <= '0;
            ovf <= 1'b0;
        end else if (sat) begin
            q   <= '1;
            r   <= '0;
            ovf <= 1'b1;
        end else if (last) begin
            q   <= w_next[Q_W-1:0];
            r   <= w_next[NUM_W-1:Q_W];
            ovf <= 1'b0;
        end
    end

    // R2
    rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf) |-> (r < {{(R_W-DEN_W){1'b0}}, d_q}));
    // R2
    window_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> !lost_bit);
    // R2
    qbit_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> !$isunknown(qbit));
    // R3
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (q == '1 && r == '0));
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> ($stable(q) && $stable(r) && $stable(ovf)));
endmodule

// File: tb/test_seqdiv_sat.sv
`timescale 1ns/1ps
module test_seqdiv_sat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] n = '0;
    logic [14:0] d = '0;
    logic        busy, done, ovf;
    logic [14:0] q;
    logic [16:0] r;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    seqdiv_sat i_seqdiv_sat (
        .clk(clk), .rst_n(rst_n), .start(start), .n(n), .d(d),
        .busy(busy), .done(done), .q(q), .r(r), .ovf(ovf)
    );

    localparam int NV = 12;
    localparam logic [46:0] VECS [NV] = '{
        {32'd100,          15'd7},
        {32'h3FFF_FFFF,    15'h7FFF},
        {32'h3FFF_7FFF,    15'h7FFF},
        {32'd0,            15'd5},
        {32'd4,            15'd5},
        {32'd123456789,    15'd12345},
        {32'hFFFF_FFFF,    15'd1},
        {32'd0,            15'd0},
        {32'h8000_0000,    15'd0},
        {32'd65535,        15'd2},
        {32'd98304,        15'd3},
        {32'd1000000,      15'd77}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // start the operation and count negedges until done is seen
    task automatic run_op(input logic [31:0] nv, input logic [14:0] dv, output int lat);
        @(negedge clk);
        n = nv; d = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic expect_result(input logic [31:0] nv, input logic [14:0] dv, input int lat);
        longint unsigned nn, dd;
        bit xo;
        nn = nv; dd = dv;
        xo = ((nn >> 15) >= dd);
        if (xo) begin
            chk(ovf == 1'b1, (dd == 0) ? "R4 ovf" : "R3 ovf", ovf, 1);
            chk(q == 15'h7fff, (dd == 0) ? "R4 q" : "R3 q", q, 15'h7fff);
            chk(r == 17'd0, "R3 r", r, 0);
            chk(lat == 1, "R6 latency", lat, 1);
        end else begin
            chk(ovf == 1'b0, "R2 ovf", ovf, 0);
            chk(q == 15'(nn / dd), "R2 q", q, nn / dd);
            chk(r == 17'(nn % dd), "R2 r", r, nn % dd);
            chk(lat == 16, "R5 latency", lat, 16);
        end
        chk(busy == 1'b1, "R5 busy during done", busy, 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7 done/busy end", {done, busy}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        logic [14:0] q_keep;
        logic [16:0] r_keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && ovf == 0, "R1 flags", {busy, done, ovf}, 0);
        chk(q == 0 && r == 0, "R1 results", {q, r}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 after release", {busy, done}, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i][46:15], VECS[i][14:0], lat);
            expect_result(VECS[i][46:15], VECS[i][14:0], lat);
        end

        // R8: mid-run start pulse with new operands is ignored
        @(negedge clk);
        n = 32'd5000000; d = 15'd999; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        n = 32'd7; d = 15'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; n = 32'd1; d = 15'd3;
        lat = 6;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(q == 15'(5000000 / 999) && ovf == 0, "R8 q", q, 5000000 / 999);
        chk(r == 17'(5000000 % 999), "R8 r", r, 5000000 % 999);
        chk(lat == 16, "R8 latency", lat, 16);
        @(negedge clk);
        chk(busy == 0, "R8 idle after run", busy, 0);

        // R9: results hold while inputs move without start
        q_keep = q; r_keep = r;
        for (int k = 0; k < 6; k++) begin
            n = 32'(k * 12345); d = 15'(k);
            @(negedge clk);
        end
        chk(q == q_keep && r == r_keep && ovf == 0 && done == 0, "R9 hold", {q, r}, {q_keep, r_keep});

        // R9: result of an overflow holds until next non-overflow completes
        run_op(32'hFFFF_0000, 15'd100, lat);
        expect_result(32'hFFFF_0000, 15'd100, lat);
        repeat (3) @(negedge clk);
        chk(q == 15'h7fff && ovf == 1, "R9 hold ovf", {ovf, q}, {1'b1, 15'h7fff});

        finish_run();
    end
endmodule